// File: doc/BRIEF.md
# Per-Core Power Sequencer

This block brings a single CPU core of a small cluster into or out of its power domain. A request carries a direction (up or down) and a core index. The block then drives that core's control outputs one action at a time: core reset, power-on reset, L1 reset disable, debug-powered-up, isolation, and an 8-bit power switch control word. Waits between actions are counted in microseconds, using a timebase derived from the `CYC_PER_US` parameter. Where the sequence must confirm a switch setting, it stops until that core's switch acknowledge reads back the expected code.

Power-up turns the switch on in six stages, each with its own settle time. It then confirms the final code and releases isolation and the resets in a fixed order. Power-down applies reset and isolation before it opens the switch. Only one sequence runs at a time. `busy` covers the sequence and a one-cycle `done` pulse marks its end. A status word reports each core's standby-in-WFI input.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset, every core has core reset and power-on reset asserted (outputs low), debug-powered-up low, L1 reset disable high, isolation enabled (high), switch control 0xFF, and busy and done low.
- R2: A power-up request (req_on=1) accepted at a clock edge drives the selected core's core reset, power-on reset, L1 reset disable and debug-powered-up low at that edge. Isolation goes high one cycle later.
- R3: Power-up then sets the switch control to 0xFE, 0xFC, 0xF8, 0xF0, 0xC0 and 0x00, in that order. The code that follows a setting held for D microseconds appears D*CYC_PER_US+1 cycles after it. D is 20 for 0xFE and 10 for each of 0xFC, 0xF8, 0xF0 and 0xC0.
- R4: After 0x00 has been held for 20 microseconds, the sequence holds until the selected core's acknowledge byte reads exactly 0x00. Isolation clears one cycle after the first cycle in which both conditions hold.
- R5: After isolation clears, power-on reset releases 20*CYC_PER_US+1 cycles later. Core reset releases one cycle after that, and debug-powered-up goes high one cycle after that.
- R6: A power-down request (req_on=0) asserts core reset at the accepting edge. Debug-powered-up goes low one cycle later and isolation goes high one cycle after that. The switch control goes to 0xFF 20*CYC_PER_US+1 cycles after isolation. The sequence then waits 30 microseconds and until the acknowledge reads 0xFF.
- R7: busy is high from the cycle after the accepting edge until the sequence ends. done is high for exactly one cycle, the cycle after the last exit condition holds, and busy is low in that cycle.
- R8: A request presented while busy is ignored and does not change any core's outputs or the running sequence.
- R9: During a sequence, the outputs of cores other than the selected one do not change.
- R10: Bit 16+i of status_word equals wfi_in[i] in the same cycle. All other status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_on | input | 1 | 1 = power up, 0 = power down |
| req_core | input | CORE_W | Index of the core to sequence |
| sw_ack | input | NUM_CORES*8 | Per-core power switch acknowledge bytes |
| wfi_in | input | NUM_CORES | Per-core standby-in-WFI flags |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| core_rst_n | output | NUM_CORES | Core reset, active low |
| por_rst_n | output | NUM_CORES | Power-on reset, active low |
| l1_rst_dis | output | NUM_CORES | L1 reset disable |
| dbg_pwrup | output | NUM_CORES | Debug-powered-up indication |
| iso_en | output | NUM_CORES | Isolation (power-off gating) enable |
| sw_ctrl | output | NUM_CORES*8 | Per-core power switch control bytes |
| status_word | output | 32 | Standby status, bit 16+i for core i |

## Verification
The first action of a sequence lands at the accepting edge. Each later action lands D*CYC_PER_US+1 cycles after the previous one, where D is the previous step's wait in microseconds. An acknowledge wait can stretch that gap, and done rises one cycle after the final exit. The bench keeps a reference model that advances one step per cycle using these rules. It compares every core's outputs against that model, plus busy and done, at each falling edge, so any early or late action shows up as a mismatch in that exact cycle. Status bits are combinational and are checked in the same cycle the WFI inputs change.

// File: rtl/core_pwr_pkg.sv
// Shared types and the step program for the per-core power sequencer.
// Assumes at most 16 steps per direction and waits below 64 microseconds.
package core_pwr_pkg;

    localparam int SW_W   = 8;   // switch control / acknowledge width
    localparam int US_W   = 6;   // microsecond wait field width
    localparam int STEP_W = 4;   // step index width

    // Settle times in microseconds.
    localparam int T_SW_FIRST = 20;
    localparam int T_SW_MID   = 10;
    localparam int T_SW_FINAL = 20;
    localparam int T_ISO_REL  = 20;
    localparam int T_DN_ISO   = 20;
    localparam int T_DN_SW    = 30;

    typedef enum logic [3:0] {
        ACT_NONE,
        ACT_UP_PREP,
        ACT_ISO_ON,
        ACT_SW,
        ACT_ISO_OFF,
        ACT_POR_REL,
        ACT_CORE_REL,
        ACT_DBG_HI,
        ACT_CORE_RST,
        ACT_DBG_LO
    } act_e;

    typedef struct packed {
        act_e            act;
        logic [SW_W-1:0] sw;
        logic [US_W-1:0] us;
        logic            ack;
        logic            last;
    } step_t;

    // Returns the action, wait, acknowledge check and end flag of one step.
    function automatic step_t step_of(input logic on, input logic [STEP_W-1:0] idx);
        step_t s;
        s = '0;
        if (on) begin
            case (idx)
                4'd0:  s.act = ACT_UP_PREP;
                4'd1:  s.act = ACT_ISO_ON;
                4'd2:  begin s.act = ACT_SW; s.sw = 8'hFE; s.us = US_W'(T_SW_FIRST); end
                4'd3:  begin s.act = ACT_SW; s.sw = 8'hFC; s.us = US_W'(T_SW_MID);   end
                4'd4:  begin s.act = ACT_SW; s.sw = 8'hF8; s.us = US_W'(T_SW_MID);   end
                4'd5:  begin s.act = ACT_SW; s.sw = 8'hF0; s.us = US_W'(T_SW_MID);   end
                4'd6:  begin s.act = ACT_SW; s.sw = 8'hC0; s.us = US_W'(T_SW_MID);   end
                4'd7:  begin s.act = ACT_SW; s.sw = 8'h00; s.us = US_W'(T_SW_FINAL); s.ack = 1'b1; end
                4'd8:  begin s.act = ACT_ISO_OFF; s.us = US_W'(T_ISO_REL); end
                4'd9:  s.act = ACT_POR_REL;
                4'd10: s.act = ACT_CORE_REL;
                default: begin s.act = ACT_DBG_HI; s.last = 1'b1; end
            endcase
        end else begin
            case (idx)
                4'd0:  s.act = ACT_CORE_RST;
                4'd1:  s.act = ACT_DBG_LO;
                4'd2:  begin s.act = ACT_ISO_ON; s.us = US_W'(T_DN_ISO); end
                default: begin
                    s.act = ACT_SW; s.sw = 8'hFF; s.us = US_W'(T_DN_SW);
                    s.ack = 1'b1; s.last = 1'b1;
                end
            endcase
        end
        return s;
    endfunction

    function automatic act_e step_act(input logic on, input logic [STEP_W-1:0] idx);
        step_t s;
        s = step_of(on, idx);
        return s.act;
    endfunction

    function automatic logic [SW_W-1:0] step_sw(input logic on, input logic [STEP_W-1:0] idx);
        step_t s;
        s = step_of(on, idx);
        return s.sw;
    endfunction

    function automatic logic [US_W-1:0] step_us(input logic on, input logic [STEP_W-1:0] idx);
        step_t s;
        s = step_of(on, idx);
        return s.us;
    endfunction

    function automatic logic step_ack(input logic on, input logic [STEP_W-1:0] idx);
        step_t s;
        s = step_of(on, idx);
        return s.ack;
    endfunction

    function automatic logic step_last(input logic on, input logic [STEP_W-1:0] idx);
        step_t s;
        s = step_of(on, idx);
        return s.last;
    endfunction

endpackage

// File: rtl/core_pwr_timebase.sv
// Microsecond wait timer. A load starts a wait of load_us microseconds;
// each microsecond lasts CYC_PER_US cycles. expired is high once the wait
// has run out (at once for a zero wait). Assumes CYC_PER_US >= 1.
module core_pwr_timebase
    import core_pwr_pkg::*;
#(
    parameter int CYC_PER_US = 100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [US_W-1:0] load_us,
    output logic            expired
);
    localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);

    logic [PRE_W-1:0] pre_q;
    logic [US_W-1:0]  us_left_q;

    // Count prescaler cycles and whole microseconds down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q     <= '0;
            us_left_q <= '0;
        end else if (load) begin
            pre_q     <= '0;
            us_left_q <= load_us;
        end else if (us_left_q != '0) begin
            if (pre_q == PRE_LAST) begin
                pre_q     <= '0;
                us_left_q <= us_left_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign expired = (us_left_q == '0);
endmodule

// File: rtl/core_pwr_lane.sv
// Output registers of one core. An apply strobe carries out one action on
// this core's signals; without it the signals hold. Reset leaves the core
// powered off: switch open, isolated, resets asserted.
module core_pwr_lane
    import core_pwr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            apply,
    input  act_e            act,
    input  logic [SW_W-1:0] sw_val,
    output logic            core_rst_n,
    output logic            por_rst_n,
    output logic            l1_rst_dis,
    output logic            dbg_pwrup,
    output logic            iso_en,
    output logic [SW_W-1:0] sw_ctrl
);
    // Update this core's signals for the action being applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_rst_n <= 1'b0;
            por_rst_n  <= 1'b0;
            l1_rst_dis <= 1'b1;
            dbg_pwrup  <= 1'b0;
            iso_en     <= 1'b1;
            sw_ctrl    <= '1;
        end else if (apply) begin
            case (act)
                ACT_UP_PREP: begin
                    core_rst_n <= 1'b0;
                    por_rst_n  <= 1'b0;
                    l1_rst_dis <= 1'b0;
                    dbg_pwrup  <= 1'b0;
                end
                ACT_ISO_ON:   iso_en     <= 1'b1;
                ACT_SW:       sw_ctrl    <= sw_val;
                ACT_ISO_OFF:  iso_en     <= 1'b0;
                ACT_POR_REL:  por_rst_n  <= 1'b1;
                ACT_CORE_REL: core_rst_n <= 1'b1;
                ACT_DBG_HI:   dbg_pwrup  <= 1'b1;
                ACT_CORE_RST: core_rst_n <= 1'b0;
                ACT_DBG_LO:   dbg_pwrup  <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/core_pwr_ctrl.sv
// Step sequencer. It accepts a request when idle, then walks the step
// program for the requested direction. It leaves a step once the step's
// wait has expired and, for acknowledge steps, once ack_sel equals the
// step's switch code. The next step's action is issued at that edge.
// Requests arriving while running are dropped.
module core_pwr_ctrl
    import core_pwr_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_on,
    input  logic [CORE_W-1:0] req_core,
    input  logic [SW_W-1:0]   ack_sel,
    input  logic              tmr_expired,
    output logic              apply,
    output act_e              act,
    output logic [SW_W-1:0]   sw_val,
    output logic [CORE_W-1:0] sel_core,
    output logic              tmr_load,
    output logic [US_W-1:0]   tmr_us,
    output logic              busy,
    output logic              done
);
    typedef enum logic {S_IDLE, S_RUN} st_e;

    st_e               state_q;
    logic              on_q;
    logic [CORE_W-1:0] core_q;
    logic [STEP_W-1:0] idx_q;
    logic [STEP_W-1:0] idx_nx;
    logic              start;
    logic              exit_ok;
    logic              advance;
    logic              cur_last;

    // Decide start, step exit and the action issued this cycle.
    always_comb begin
        idx_nx   = idx_q + 1'b1;
        cur_last = step_last(on_q, idx_q);
        start    = (state_q == S_IDLE) && req_valid && (32'(req_core) < NUM_CORES);
        exit_ok  = (state_q == S_RUN) && tmr_expired &&
                   (!step_ack(on_q, idx_q) || (ack_sel == step_sw(on_q, idx_q)));
        advance  = exit_ok && !cur_last;
        apply    = start || advance;
        tmr_load = apply;
        if (start) begin
            act    = step_act(req_on, '0);
            sw_val = step_sw(req_on, '0);
            tmr_us = step_us(req_on, '0);
        end else begin
            act    = step_act(on_q, idx_nx);
            sw_val = step_sw(on_q, idx_nx);
            tmr_us = step_us(on_q, idx_nx);
        end
        sel_core = (state_q == S_IDLE) ? req_core : core_q;
    end

    // Track the running request, its step index and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            on_q    <= 1'b0;
            core_q  <= '0;
            idx_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= exit_ok && cur_last;
            if (start) begin
                state_q <= S_RUN;
                on_q    <= req_on;
                core_q  <= req_core;
                idx_q   <= '0;
            end else if (exit_ok) begin
                if (cur_last) state_q <= S_IDLE;
                else          idx_q   <= idx_nx;
            end
        end
    end

    assign busy = (state_q == S_RUN);
endmodule

// File: rtl/core_pwr_seq.sv
// Top of the per-core power sequencer: one step controller, one wait
// timer and one lane of output registers per core. Only the lane of the
// selected core receives apply strobes. Assumes NUM_CORES <= 16 so that
// the standby flags fit in status bits 16 and up.
module core_pwr_seq
    import core_pwr_pkg::*;
#(
    parameter  int NUM_CORES  = 4,
    parameter  int CYC_PER_US = 100,
    localparam int CORE_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_on,
    input  logic [CORE_W-1:0]         req_core,
    input  logic [NUM_CORES*SW_W-1:0] sw_ack,
    input  logic [NUM_CORES-1:0]      wfi_in,
    output logic                      busy,
    output logic                      done,
    output logic [NUM_CORES-1:0]      core_rst_n,
    output logic [NUM_CORES-1:0]      por_rst_n,
    output logic [NUM_CORES-1:0]      l1_rst_dis,
    output logic [NUM_CORES-1:0]      dbg_pwrup,
    output logic [NUM_CORES-1:0]      iso_en,
    output logic [NUM_CORES*SW_W-1:0] sw_ctrl,
    output logic [31:0]               status_word
);
    localparam int STAT_BASE = 16;

    logic              apply;
    act_e              act;
    logic [SW_W-1:0]   sw_val;
    logic [CORE_W-1:0] sel_core;
    logic              tmr_load;
    logic [US_W-1:0]   tmr_us;
    logic              tmr_expired;
    logic [SW_W-1:0]   ack_sel;

    // Pick the acknowledge byte of the core being sequenced.
    always_comb begin
        ack_sel = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (32'(sel_core) == i) ack_sel = sw_ack[i*SW_W +: SW_W];
        end
    end

    core_pwr_ctrl #(
        .NUM_CORES (NUM_CORES),
        .CORE_W    (CORE_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_on      (req_on),
        .req_core    (req_core),
        .ack_sel     (ack_sel),
        .tmr_expired (tmr_expired),
        .apply       (apply),
        .act         (act),
        .sw_val      (sw_val),
        .sel_core    (sel_core),
        .tmr_load    (tmr_load),
        .tmr_us      (tmr_us),
        .busy        (busy),
        .done        (done)
    );

    core_pwr_timebase #(
        .CYC_PER_US (CYC_PER_US)
    ) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_us (tmr_us),
        .expired (tmr_expired)
    );

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_lane
        logic lane_apply;
        assign lane_apply = apply && (32'(sel_core) == g);
        core_pwr_lane lane_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .apply      (lane_apply),
            .act        (act),
            .sw_val     (sw_val),
            .core_rst_n (core_rst_n[g]),
            .por_rst_n  (por_rst_n[g]),
            .l1_rst_dis (l1_rst_dis[g]),
            .dbg_pwrup  (dbg_pwrup[g]),
            .iso_en     (iso_en[g]),
            .sw_ctrl    (sw_ctrl[g*SW_W +: SW_W])
        );
    end

    // Place each core's standby flag at its status bit.
    always_comb begin
        status_word = '0;
        for (int i = 0; i < NUM_CORES; i++) status_word[STAT_BASE + i] = wfi_in[i];
    end
endmodule

// File: rtl/core_pwr_seq_chk.sv
// Assertion checker for core_pwr_seq, bound to every instance.
module core_pwr_seq_chk
    import core_pwr_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      busy,
    input logic                      done,
    input logic [NUM_CORES-1:0]      core_rst_n,
    input logic [NUM_CORES-1:0]      por_rst_n,
    input logic [NUM_CORES-1:0]      l1_rst_dis,
    input logic [NUM_CORES-1:0]      dbg_pwrup,
    input logic [NUM_CORES-1:0]      iso_en,
    input logic [NUM_CORES*SW_W-1:0] sw_ctrl,
    input logic [NUM_CORES*SW_W-1:0] sw_ack
);
    localparam int LW = 5 + SW_W;

    logic [NUM_CORES-1:0] chg;
    logic                 seen_q;

    // Note that at least one clock edge has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        logic [LW-1:0] now_v, prev_q;
        assign now_v = {core_rst_n[g], por_rst_n[g], l1_rst_dis[g], dbg_pwrup[g],
                        iso_en[g], sw_ctrl[g*SW_W +: SW_W]};

        // Keep last cycle's outputs of this core.
        always_ff @(posedge clk) prev_q <= now_v;
        assign chg[g] = seen_q && (now_v != prev_q);

        // R5: core reset releases only after power-on reset is released
        a_r5_core_after_por: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(core_rst_n[g]) |-> por_rst_n[g]);
        // R5: power-on reset releases only with isolation already cleared
        a_r5_por_after_iso: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(por_rst_n[g]) |-> !iso_en[g]);
        // R4: isolation clears only after the acknowledge read back 0x00
        a_r4_iso_off_acked: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(iso_en[g]) |-> ($past(sw_ack[g*SW_W +: SW_W]) == '0));
        // R6: the switch opens only while the core is isolated
        a_r6_open_isolated: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q && sw_ctrl[g*SW_W +: SW_W] == '1 && $past(sw_ctrl[g*SW_W +: SW_W]) != '1)
            |-> iso_en[g]);
    end

    // R7: done lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: done coincides with the end of busy
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9: at most one core's outputs move in any cycle
    a_r9_one_core: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chg) <= 1);
endmodule

bind core_pwr_seq core_pwr_seq_chk #(.NUM_CORES(NUM_CORES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .core_rst_n (core_rst_n),
    .por_rst_n  (por_rst_n),
    .l1_rst_dis (l1_rst_dis),
    .dbg_pwrup  (dbg_pwrup),
    .iso_en     (iso_en),
    .sw_ctrl    (sw_ctrl),
    .sw_ack     (sw_ack)
);

// File: tb/core_pwr_seq_tb_top.sv
module core_pwr_seq_tb_top;
    localparam int N   = 4;
    localparam int CYC = 2;
    localparam int CW  = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            req_valid;
    logic            req_on;
    logic [CW-1:0]   req_core;
    logic [N*8-1:0]  sw_ack;
    logic [N-1:0]    wfi_in;
    logic            busy, done;
    logic [N-1:0]    core_rst_n, por_rst_n, l1_rst_dis, dbg_pwrup, iso_en;
    logic [N*8-1:0]  sw_ctrl;
    logic [31:0]     status_word;

    always #4 clk = ~clk;

    core_pwr_seq #(.NUM_CORES(N), .CYC_PER_US(CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on),
        .req_core(req_core), .sw_ack(sw_ack), .wfi_in(wfi_in), .busy(busy),
        .done(done), .core_rst_n(core_rst_n), .por_rst_n(por_rst_n),
        .l1_rst_dis(l1_rst_dis), .dbg_pwrup(dbg_pwrup), .iso_en(iso_en),
        .sw_ctrl(sw_ctrl), .status_word(status_word)
    );

    typedef struct packed {
        logic       crn, por, l1, dbg, iso;
        logic [7:0] sw;
    } cs_t;

    cs_t mdl [N];
    int  checks = 0;
    int  errors = 0;
    int  hold_core = 0;
    int  hold_left = 0;
    logic [7:0] hold_target = 8'h00;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int us_of(input bit on, input int idx);
        if (on) begin
            case (idx)
                2: return 20; 3, 4, 5, 6: return 10; 7: return 20; 8: return 20;
                default: return 0;
            endcase
        end
        case (idx) 2: return 20; 3: return 30; default: return 0; endcase
    endfunction

    function automatic int last_of(input bit on);
        return on ? 11 : 3;
    endfunction

    function automatic string tag_of(input bit on, input int idx);
        if (!on) return "R6";
        if (idx < 2) return "R2";
        if (idx < 7) return "R3";
        if (idx == 7) return "R4";
        return "R5";
    endfunction

    // Expected state of a core after a step is carried out.
    function automatic cs_t next_of(input cs_t s, input bit on, input int idx);
        cs_t r = s;
        if (on) begin
            case (idx)
                0: begin r.crn = 0; r.por = 0; r.l1 = 0; r.dbg = 0; end
                1: r.iso = 1;
                2: r.sw = 8'hFE; 3: r.sw = 8'hFC; 4: r.sw = 8'hF8;
                5: r.sw = 8'hF0; 6: r.sw = 8'hC0; 7: r.sw = 8'h00;
                8: r.iso = 0; 9: r.por = 1; 10: r.crn = 1;
                default: r.dbg = 1;
            endcase
        end else begin
            case (idx)
                0: r.crn = 0; 1: r.dbg = 0; 2: r.iso = 1;
                default: r.sw = 8'hFF;
            endcase
        end
        return r;
    endfunction

    function automatic cs_t actual_of(input int c);
        return {core_rst_n[c], por_rst_n[c], l1_rst_dis[c], dbg_pwrup[c],
                iso_en[c], sw_ctrl[c*8 +: 8]};
    endfunction

    // Move to the next falling edge, update the switch acknowledges, settle.
    task automatic step_cycle();
        @(negedge clk);
        for (int c = 0; c < N; c++) begin
            if (c == hold_core && hold_left > 0 && sw_ctrl[c*8 +: 8] == hold_target) begin
                sw_ack[c*8 +: 8] = 8'h5A;
                hold_left--;
            end else begin
                sw_ack[c*8 +: 8] = sw_ctrl[c*8 +: 8];
            end
        end
        #1;
    endtask

    task automatic compare_all(input int sel, input string sel_tag);
        for (int c = 0; c < N; c++)
            chk(actual_of(c) == mdl[c], (c == sel) ? sel_tag : "R9",
                $sformatf("core%0d state", c), actual_of(c), mdl[c]);
    endtask

    // One full sequence, checked against the step model every cycle.
    task automatic run_seq(input bit on, input int core, input int hold, input bit noise);
        int  k = 0, t = 0, idx = 0;
        bit  fin = 0;
        bit  cond;
        hold_core   = core;
        hold_left   = hold;
        hold_target = on ? 8'h00 : 8'hFF;
        req_valid = 1'b1; req_on = on; req_core = CW'(core);
        @(posedge clk);
        mdl[core] = next_of(mdl[core], on, 0);
        forever begin
            step_cycle();
            req_valid = 1'b0;
            compare_all(core, tag_of(on, idx));
            chk(busy == !fin, "R7", "busy", busy, !fin);
            chk(done == fin, "R7", "done", done, fin);
            if (fin) break;
            if (noise && ($urandom % 6 == 0)) begin
                // R8: stray request while busy, must be ignored
                req_valid = 1'b1; req_on = $urandom % 2; req_core = CW'($urandom % N);
            end
            cond = (k >= t + us_of(on, idx) * CYC);
            if ((on && idx == 7) || (!on && idx == 3))
                cond = cond && (sw_ack[core*8 +: 8] == (on ? 8'h00 : 8'hFF));
            if (cond) begin
                if (idx == last_of(on)) fin = 1;
                else begin
                    idx++;
                    mdl[core] = next_of(mdl[core], on, idx);
                    t = k + 1;
                end
            end
            k++;
            if (k > 5000) begin
                chk(0, "R7", "sequence end", k, 0);
                break;
            end
        end
        req_valid = 1'b0;
        hold_left = 0;
        step_cycle();
        compare_all(core, "R8");
    endtask

    task automatic check_status(input logic [N-1:0] bits);
        logic [31:0] exp;
        @(negedge clk);
        wfi_in = bits;
        #1;
        exp = 32'(bits) << 16;
        chk(status_word == exp, "R10", "status_word", status_word, exp);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req_valid = 1'b0; req_on = 1'b0; req_core = '0;
        sw_ack = '1; wfi_in = '0;
        for (int c = 0; c < N; c++) mdl[c] = '{crn: 0, por: 0, l1: 1, dbg: 0, iso: 1, sw: 8'hFF};
        repeat (4) step_cycle();
        rst_n = 1'b1;
        step_cycle();
        // R1: reset state of every core and the status flags
        compare_all(-1, "R1");
        chk(busy == 1'b0, "R1", "busy", busy, 0);
        chk(done == 1'b0, "R1", "done", done, 0);

        // Directed: acknowledge held past the settle time (R4), no noise.
        run_seq(1, 0, 55, 0);
        // Directed: highest core index with stray requests (R8, R9).
        run_seq(1, 3, 0, 1);
        // Directed: power-down with a late acknowledge (R6).
        run_seq(0, 0, 70, 1);
        check_status(4'b1010);
        check_status(4'b0101);
        check_status(4'b0000);
        for (int r = 0; r < 10; r++) begin
            run_seq($urandom % 2, $urandom % N, $urandom % 75, 1);
            check_status(N'($urandom));
        end
        summary();
        $finish;
    end
endmodule